// File: doc/BRIEF.md
# UART Receive Buffer with Deferred Error Flags

This block is the back end of a serial receiver. A shift register in front of it hands over one finished frame at a time as a single-cycle strobe. The frame carries the data byte, the received parity bit and the sampled stop bit. The block works out whether the frame has a framing error or a parity error. It stores the byte with both error tags in a two-slot first-in first-out buffer. The CPU reads the buffer one byte per read strobe.

Three sticky interrupt flags report receive problems: framing, parity and overrun. The framing and parity flags are not raised when the frame arrives. They are raised when the affected byte becomes the readable head of the buffer. The overrun flag is raised at once when a frame finds both slots occupied. Software clears a flag by writing 1 to its bit. A per-flag enable masks each flag into the single interrupt line.

Top module: `uart_rx_errbuf`

## Requirements
- R1: A frame whose sampled stop bit is 0 carries a framing-error tag. Flag bit 0 (`flags[0]`) reports framing.
- R2: With parity enabled, a parity error exists when the XOR of the data bits and the parity bit differs from `cfg_par_odd`. `cfg_par_odd`=0 selects even parity and 1 selects odd parity. Flag bit 1 reports parity.
- R3: With `cfg_par_en` low, no byte carries a parity-error tag, whatever the parity bit is.
- R4: A byte with a framing or parity error is stored and returned by reads like any other byte.
- R5: The buffer holds at most two bytes in arrival order. `rd_data` shows the oldest byte and `rd_avail` is high while at least one byte is stored. A read strobe with the buffer non-empty removes the oldest byte at that clock edge. Reset empties the buffer, clears all flags and sets `rd_data` to 0.
- R6: When an errored frame arrives and the buffer is empty after any same-cycle read, its flag is visible in the cycle after the frame strobe.
- R7: When an errored frame lands in the second slot, its flag stays low until the older byte is read. It becomes visible in the cycle after that read strobe.
- R8: When a frame arrives while both slots are full and no read strobe is present in that cycle, the frame is discarded and `flags[2]` is set in the next cycle. A read strobe in the same cycle frees a slot, and the frame is then stored.
- R9: Flags are sticky. A 1 in `flag_clr` clears the matching flag. A flag set in the same cycle as its clear stays set.
- R10: `irq` is high exactly when some flag is set and its bit in `irq_en` is 1.
- R11: A read strobe on an empty buffer leaves `rd_data`, `rd_avail` and the flags unchanged. After the last byte is read, `rd_data` keeps showing that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_par_en | input | 1 | Parity checking enable |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| frm_valid | input | 1 | Frame-complete strobe |
| frm_data | input | DW | Received data bits |
| frm_par | input | 1 | Received parity bit |
| frm_stop | input | 1 | Sampled stop bit |
| rd_stb | input | 1 | CPU read strobe; pops the head byte |
| rd_data | output | DW | Head byte, or the last byte if the buffer is empty |
| rd_avail | output | 1 | Buffer holds at least one byte |
| flag_clr | input | 3 | Write-1-to-clear for {overrun, parity, framing} |
| irq_en | input | 3 | Per-flag interrupt enables |
| flags | output | 3 | Sticky flags {overrun, parity, framing} |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume a few things about the inputs:
- The frame fields are meaningful only in a cycle with `frm_valid` high.
- `rd_stb` may arrive in any cycle, including cycles with an empty buffer and cycles that carry a frame.
- Configuration inputs may change between frames.

The stimulus drives every input only on the falling clock edge, so each strobe lasts exactly one clock. The random phase keeps parity enable, parity mode, stop bit and read strobe independent. This covers the simultaneous read-and-frame cases on a full buffer, on a one-entry buffer and on an empty buffer.

// File: rtl/uart_rxb_pkg.sv
package uart_rxb_pkg;
    localparam int unsigned FLAG_FE  = 0;
    localparam int unsigned FLAG_PE  = 1;
    localparam int unsigned FLAG_OVF = 2;
    localparam int unsigned NFLAG    = 3;
    localparam int unsigned SLOTS    = 2;
    localparam int unsigned CNT_W    = $clog2(SLOTS + 1);
endpackage

// File: rtl/uart_rxb_frmchk.sv
module uart_rxb_frmchk #(
    parameter int unsigned DW = 8
) (
    input  logic [DW-1:0] data,
    input  logic          par_bit,
    input  logic          stop_bit,
    input  logic          par_en,
    input  logic          par_odd,
    output logic          fe,
    output logic          pe
);
    logic par_sum;

    always_comb begin
        par_sum = (^data) ^ par_bit;
        fe      = ~stop_bit;
        pe      = par_en & (par_sum ^ par_odd);
    end
endmodule

// File: rtl/uart_rxb_fifo.sv
module uart_rxb_fifo
    import uart_rxb_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [DW-1:0]    push_data,
    input  logic             push_fe,
    input  logic             push_pe,
    input  logic             pop,
    output logic [DW-1:0]    head_data,
    output logic             head_fe,
    output logic             head_pe,
    output logic [CNT_W-1:0] cnt,
    output logic             head_load,
    output logic             overrun
);
    typedef struct packed {
        logic [DW-1:0] data;
        logic          fe;
        logic          pe;
    } slot_t;

    typedef struct packed {
        slot_t [SLOTS-1:0] slot;
        logic [CNT_W-1:0]  cnt;
    } state_t;

    state_t           st_d, st_q;
    logic             pop_ok, push_ok;
    logic [CNT_W-1:0] mid;
    slot_t            incoming;

    always_comb begin
        st_d          = st_q;
        incoming.data = push_data;
        incoming.fe   = push_fe;
        incoming.pe   = push_pe;
        pop_ok        = pop && (st_q.cnt != '0);
        mid           = st_q.cnt - {{(CNT_W-1){1'b0}}, pop_ok};
        // shift only when a second byte exists; a lone popped head stays visible
        if (pop_ok && (st_q.cnt == CNT_W'(SLOTS))) st_d.slot[0] = st_q.slot[1];
        push_ok       = push && (mid < CNT_W'(SLOTS));
        overrun       = push && !push_ok;
        if (push_ok) st_d.slot[mid[0]] = incoming;
        st_d.cnt      = mid + {{(CNT_W-1){1'b0}}, push_ok};
        head_load     = (pop_ok && (st_q.cnt == CNT_W'(SLOTS))) || (push_ok && (mid == '0));
        head_data     = st_q.slot[0].data;
        head_fe       = st_d.slot[0].fe;
        head_pe       = st_d.slot[0].pe;
        cnt           = st_q.cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/uart_rxb_flags.sv
module uart_rxb_flags #(
    parameter int unsigned NF = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set,
    input  logic [NF-1:0] clr,
    input  logic [NF-1:0] en,
    output logic [NF-1:0] flags,
    output logic          irq
);
    typedef struct packed {
        logic [NF-1:0] flg;
    } state_t;

    state_t        st_d, st_q;
    logic [NF-1:0] masked;

    always_comb begin
        st_d     = st_q;
        st_d.flg = (st_q.flg & ~clr) | set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < NF; i++) begin : g_mask
        assign masked[i] = st_q.flg[i] & en[i];
    end

    assign flags = st_q.flg;
    assign irq   = |masked;
endmodule

// File: rtl/uart_rx_errbuf.sv
module uart_rx_errbuf
    import uart_rxb_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_par_en,
    input  logic             cfg_par_odd,
    input  logic             frm_valid,
    input  logic [DW-1:0]    frm_data,
    input  logic             frm_par,
    input  logic             frm_stop,
    input  logic             rd_stb,
    output logic [DW-1:0]    rd_data,
    output logic             rd_avail,
    input  logic [NFLAG-1:0] flag_clr,
    input  logic [NFLAG-1:0] irq_en,
    output logic [NFLAG-1:0] flags,
    output logic             irq
);
    logic             new_fe, new_pe;
    logic             head_fe, head_pe, head_load, overrun;
    logic [CNT_W-1:0] fifo_cnt;
    logic [NFLAG-1:0] flag_set;

    uart_rxb_frmchk #(.DW(DW)) u_chk_frame (
        .data     (frm_data),
        .par_bit  (frm_par),
        .stop_bit (frm_stop),
        .par_en   (cfg_par_en),
        .par_odd  (cfg_par_odd),
        .fe       (new_fe),
        .pe       (new_pe)
    );

    uart_rxb_fifo #(.DW(DW)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (frm_valid),
        .push_data (frm_data),
        .push_fe   (new_fe),
        .push_pe   (new_pe),
        .pop       (rd_stb),
        .head_data (rd_data),
        .head_fe   (head_fe),
        .head_pe   (head_pe),
        .cnt       (fifo_cnt),
        .head_load (head_load),
        .overrun   (overrun)
    );

    always_comb begin
        flag_set           = '0;
        flag_set[FLAG_FE]  = head_load & head_fe;
        flag_set[FLAG_PE]  = head_load & head_pe;
        flag_set[FLAG_OVF] = overrun;
    end

    uart_rxb_flags #(.NF(NFLAG)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clr   (flag_clr),
        .en    (irq_en),
        .flags (flags),
        .irq   (irq)
    );

    assign rd_avail = (fifo_cnt != '0);
endmodule

// File: rtl/uart_rx_errbuf_chk.sv
module uart_rx_errbuf_chk #(
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frm_valid,
    input logic          frm_stop,
    input logic          rd_stb,
    input logic [2:0]    flag_clr,
    input logic [2:0]    flags,
    input logic [DW-1:0] rd_data,
    input logic [1:0]    cnt
);
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt != 2'd3);

    assert_fe_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !frm_stop && cnt == 2'd0) |=> flags[0]);

    assert_ovf_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !rd_stb && cnt == 2'd2) |=> (flags[2] && cnt == 2'd2));

    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & $past(flags & ~flag_clr)) == $past(flags & ~flag_clr)));

    assert_empty_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !frm_valid && cnt == 2'd0) |=> ($stable(rd_data) && cnt == 2'd0));

    assert_held_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == 2'd2 && !rd_stb) |=> $stable(rd_data));
endmodule

bind uart_rx_errbuf uart_rx_errbuf_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .frm_valid(frm_valid),
    .frm_stop (frm_stop),
    .rd_stb   (rd_stb),
    .flag_clr (flag_clr),
    .flags    (flags),
    .rd_data  (rd_data),
    .cnt      (fifo_cnt)
);

// File: tb/uart_rx_errbuf_tb.sv
module uart_rx_errbuf_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic       frm_valid = 1'b0, frm_par = 1'b0, frm_stop = 1'b1;
    logic [7:0] frm_data = '0;
    logic       rd_stb = 1'b0;
    logic [2:0] flag_clr = '0, irq_en = '0;
    logic [7:0] rd_data;
    logic       rd_avail, irq;
    logic [2:0] flags;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    string cur_req = "R5";

    always #5 clk = ~clk;

    uart_rx_errbuf #(.DW(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .frm_valid(frm_valid), .frm_data(frm_data), .frm_par(frm_par), .frm_stop(frm_stop),
        .rd_stb(rd_stb), .rd_data(rd_data), .rd_avail(rd_avail),
        .flag_clr(flag_clr), .irq_en(irq_en), .flags(flags), .irq(irq)
    );

    // reference model: entry = {fe, pe, data}
    logic [9:0] mq[$];
    logic [7:0] m_last = '0;
    logic [2:0] m_flags = '0;

    always @(posedge clk) begin
        logic [2:0] st;
        logic [9:0] e;
        st = '0;
        if (!rst_n) begin
            mq.delete();
            m_last  = '0;
            m_flags = '0;
        end else begin
            if (rd_stb && mq.size() > 0) begin
                void'(mq.pop_front());
                if (mq.size() > 0) st = st | {1'b0, mq[0][8], mq[0][9]};
            end
            if (frm_valid) begin
                e[9]   = ~frm_stop;
                e[8]   = cfg_par_en && (((^frm_data) ^ frm_par) != cfg_par_odd);
                e[7:0] = frm_data;
                if (mq.size() < 2) begin
                    mq.push_back(e);
                    if (mq.size() == 1) st = st | {1'b0, e[8], e[9]};
                end else begin
                    st[2] = 1'b1;
                end
            end
            if (mq.size() > 0) m_last = mq[0][7:0];
            m_flags = (m_flags & ~flag_clr) | st;
        end
    end

    task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare();
        chk("rd_data",  rd_data, m_last);
        chk("rd_avail", {7'b0, rd_avail}, {7'b0, mq.size() != 0});
        chk("flags",    {5'b0, flags}, {5'b0, m_flags});
        chk("irq",      {7'b0, irq}, {7'b0, |(m_flags & irq_en)});
    endtask

    task automatic step(bit v, logic [7:0] d, bit p, bit s, bit rd, logic [2:0] clr);
        @(negedge clk);
        compare();
        frm_valid = v; frm_data = d; frm_par = p; frm_stop = s;
        rd_stb = rd; flag_clr = clr;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 8'h00, 0, 1, 0, 3'b000);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual running expected done");
        finish_run();
    end

    initial begin
        irq_en = 3'b111;
        cur_req = "R5"; // reset state
        repeat (3) @(negedge clk);
        compare();
        rst_n = 1'b1;
        idle(1);

        cur_req = "R11"; // read of empty buffer
        step(0, 0, 0, 1, 1, 0); idle(2);

        cur_req = "R1"; // stop bit 0, empty buffer
        step(1, 8'hA5, 0, 0, 0, 0); idle(1);
        cur_req = "R4"; // errored byte still readable
        step(0, 0, 0, 1, 1, 0); idle(1);
        cur_req = "R11"; // after last read, data stays
        step(0, 0, 0, 1, 1, 0); idle(1);

        cur_req = "R9"; // clear, and set winning over clear
        step(0, 0, 0, 1, 0, 3'b001); idle(1);
        step(1, 8'h3C, 0, 0, 0, 3'b001); idle(1);
        step(0, 0, 0, 1, 1, 3'b111); idle(1);

        cur_req = "R2"; // even then odd parity mismatch
        cfg_par_en = 1; cfg_par_odd = 0;
        step(1, 8'h01, 0, 1, 0, 0); idle(1);
        step(0, 0, 0, 1, 1, 3'b111); idle(1);
        cfg_par_odd = 1;
        step(1, 8'h03, 0, 1, 0, 0); idle(1);
        step(1, 8'h07, 0, 1, 1, 3'b111); idle(1);
        step(0, 0, 0, 1, 1, 3'b111); idle(1);

        cur_req = "R3"; // parity disabled
        cfg_par_en = 0;
        step(1, 8'h01, 0, 1, 0, 0); idle(1);
        step(0, 0, 0, 1, 1, 0); idle(1);

        cur_req = "R7"; // errored byte in second slot
        step(1, 8'h11, 0, 1, 0, 0);
        step(1, 8'h22, 0, 0, 0, 0); idle(3);
        step(0, 0, 0, 1, 1, 0); idle(1);
        step(0, 0, 0, 1, 1, 3'b111); idle(1);

        cur_req = "R8"; // overrun, then frame with simultaneous read
        step(1, 8'h44, 0, 1, 0, 0);
        step(1, 8'h55, 0, 1, 0, 0);
        step(1, 8'h66, 0, 1, 0, 0); idle(1);
        step(1, 8'h77, 0, 1, 1, 3'b100); idle(1);
        step(0, 0, 0, 1, 1, 0);
        step(0, 0, 0, 1, 1, 0); idle(1);

        cur_req = "R10"; // enable masking
        step(1, 8'h88, 0, 0, 0, 0);
        irq_en = 3'b110; idle(1);
        irq_en = 3'b001; idle(1);
        irq_en = 3'b000; step(0, 0, 0, 1, 1, 3'b111); idle(1);

        cur_req = "R6"; // empty-after-read path with errored frame
        irq_en = 3'b111;
        step(1, 8'h99, 0, 1, 0, 0);
        step(1, 8'h9A, 0, 0, 1, 0); idle(2);
        step(0, 0, 0, 1, 1, 3'b111); idle(1);

        cur_req = "R5"; // random mixture
        for (int i = 0; i < 3000; i++) begin
            cfg_par_en  = $urandom_range(0, 1);
            cfg_par_odd = $urandom_range(0, 1);
            irq_en      = 3'($urandom_range(0, 7));
            step($urandom_range(0, 99) < 45, 8'($urandom), $urandom_range(0, 1),
                 $urandom_range(0, 9) != 0, $urandom_range(0, 99) < 40,
                 ($urandom_range(0, 9) == 0) ? 3'($urandom_range(0, 7)) : 3'b000);
        end
        idle(2);
        finish_run();
    end
endmodule